// File: doc/BRIEF.md
# MII to RMII transmit converter

This block sits between an Ethernet MAC that speaks the 4-bit MII transmit interface and a PHY that takes the 2-bit RMII transmit interface. It runs entirely from the single 50 MHz RMII reference clock. From that clock it derives the MII transmit clock it hands to the MAC. At every rising edge of that MII clock it captures one nibble, together with its enable and error flags. It then sends the nibble to the PHY as two dibits, each with an RMII transmit enable.

The parameter `LOW_SPEED` selects the line rate. At 0 the link runs at 100 Mbps: each dibit lasts one reference cycle and the MII clock is 25 MHz. At 1 the link runs at 10 Mbps: each dibit lasts `SLOW_DIV` (ten) reference cycles and the MII clock is 2.5 MHz. Frame bytes pass through unchanged. The one exception is a transmit error: from the nibble that raises the error up to the end of the frame, the block sends a fixed 01 pattern instead of the MAC data.

Top module: `mii_rmii_tx`

## Requirements
- R1: While `rst_n` is low, `rmii_txd`, `rmii_tx_en` and `mii_tx_clk` are all zero, and the clock divider restarts from its initial phase.
- R2: `mii_tx_clk` stays high for P reference cycles and then low for P reference cycles. P is 1 when `LOW_SPEED`=0 and `SLOW_DIV` (10) when `LOW_SPEED`=1.
- R3: The MII inputs are captured on the reference edge at which `mii_tx_clk` rises. From that edge `rmii_txd` carries bits [1:0] of the captured nibble. From the edge at which `mii_tx_clk` falls it carries bits [3:2].
- R4: Every dibit on `rmii_txd` and `rmii_tx_en` is held for exactly P reference cycles.
- R5: `rmii_tx_en` equals the captured `mac_tx_en` and stays the same for both dibits of a nibble. It therefore rises with the first dibit of the first enabled nibble and falls after the second dibit of the last one.
- R6: A nibble captured with `mac_tx_en` low sends dibits 00 with `rmii_tx_en` low, whatever `mac_txd` and `mac_tx_er` hold.
- R7: When an enabled nibble is captured with `mac_tx_er` high, both of its dibits are 01. Both dibits of every later enabled nibble in the same frame are also 01, even after `mac_tx_er` returns low.
- R8: Capturing a nibble with `mac_tx_en` low clears the error state, so the next frame passes its data through unchanged.
- R9: When no error is active, the two dibits of an enabled nibble reproduce all four data bits exactly, for all 16 nibble values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | 50 MHz RMII reference clock; the only clock of the block |
| rst_n | input | 1 | Active-low asynchronous reset |
| mac_txd | input | 4 | MII transmit nibble from the MAC |
| mac_tx_en | input | 1 | MII transmit enable from the MAC |
| mac_tx_er | input | 1 | MII transmit error from the MAC |
| mii_tx_clk | output | 1 | Derived MII transmit clock toward the MAC |
| rmii_txd | output | 2 | RMII transmit dibit toward the PHY |
| rmii_tx_en | output | 1 | RMII transmit enable toward the PHY |

## Verification
The bench builds two copies side by side. `u0` uses `LOW_SPEED`=0, so every nibble takes two reference cycles and all 16 nibble values, error frames and idle gaps can be swept in a few hundred cycles. `u1` uses `LOW_SPEED`=1 with the default `SLOW_DIV` of 10, which brings the ten-cycle dibit hold and the 2.5 MHz clock period within reach. Both copies receive the same input sequence and are reset before each phase. Each check compares against dibits computed arithmetically in the bench from the nibble, the enable and the error history.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

  // Reference cycles per dibit for the selected line rate.
  function automatic int unsigned dibit_cycles(input bit low_speed, input int unsigned slow_div);
    return low_speed ? slow_div : 1;
  endfunction

  // Dibit sent for one half of a nibble.
  // hi_half=0 picks bits [1:0], hi_half=1 picks bits [3:2].
  function automatic logic [1:0] pick_dibit(input logic [3:0] nib, input logic en,
                                            input logic subst, input logic hi_half);
    if (!en)        return 2'b00;
    else if (subst) return 2'b01;
    else if (hi_half) return nib[3:2];
    else            return nib[1:0];
  endfunction

endpackage

// File: rtl/mrt_pacer.sv
module mrt_pacer #(
  parameter int unsigned PERIOD = 1
) (
  input  logic ref_clk,
  input  logic rst_n,
  output logic mii_clk,
  output logic cap_evt,
  output logic hi_evt
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt;
  logic          phase;
  logic          tick;

  assign tick    = (cnt == CW'(PERIOD - 1));
  assign cap_evt = tick & ~phase;
  assign hi_evt  = tick & phase;
  assign mii_clk = phase;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else begin
      cnt   <= tick ? '0 : cnt + 1'b1;
      phase <= tick ? ~phase : phase;
    end
  end

  a_r2_toggle_on_tick: assert property (@(posedge ref_clk) disable iff (!rst_n)
    tick |=> (mii_clk != $past(mii_clk)));
  a_r2_steady_between: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !tick |=> $stable(mii_clk));
  a_r4_count_bound: assert property (@(posedge ref_clk) disable iff (!rst_n)
    cnt <= CW'(PERIOD - 1));

endmodule

// File: rtl/mrt_errtrack.sv
module mrt_errtrack (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic cap_evt,
  input  logic tx_en,
  input  logic tx_er,
  output logic subst
);
  logic err_q;

  // Substitution applies to the nibble raising the error and every later one in the frame.
  assign subst = tx_en & (tx_er | err_q);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (cap_evt) err_q <= subst;
  end

  a_r8_clear_on_idle: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (cap_evt && !tx_en) |=> !err_q);
  a_r7_sticky: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (cap_evt && tx_en && tx_er) |=> err_q);

endmodule

// File: rtl/mrt_serializer.sv
module mrt_serializer
  import mrt_pkg::*;
(
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       cap_evt,
  input  logic       hi_evt,
  input  logic [3:0] nib,
  input  logic       tx_en,
  input  logic       subst,
  output logic [1:0] txd,
  output logic       txen
);
  logic [1:0] hi_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      txd  <= 2'b00;
      txen <= 1'b0;
      hi_q <= 2'b00;
    end else if (cap_evt) begin
      txd  <= pick_dibit(nib, tx_en, subst, 1'b0);
      hi_q <= pick_dibit(nib, tx_en, subst, 1'b1);
      txen <= tx_en;
    end else if (hi_evt) begin
      txd  <= hi_q;
    end
  end

  a_r4_hold: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(cap_evt || hi_evt) |=> ($stable(txd) && $stable(txen)));
  a_r5_en_spans_nibble: assert property (@(posedge ref_clk) disable iff (!rst_n)
    hi_evt |=> $stable(txen));
  a_r6_idle_zero: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (cap_evt && !tx_en) |=> (txd == 2'b00 && !txen));
  a_r7_err_pattern: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (cap_evt && subst) |=> (txd == 2'b01));

endmodule

// File: rtl/mii_rmii_tx.sv
module mii_rmii_tx
  import mrt_pkg::*;
#(
  parameter bit          LOW_SPEED = 1'b0,
  parameter int unsigned SLOW_DIV  = 10
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic [3:0] mac_txd,
  input  logic       mac_tx_en,
  input  logic       mac_tx_er,
  output logic       mii_tx_clk,
  output logic [1:0] rmii_txd,
  output logic       rmii_tx_en
);
  localparam int unsigned PERIOD = dibit_cycles(LOW_SPEED, SLOW_DIV);

  // Named internal events, shared by the submodules and the assertions.
  logic cap_evt;
  logic hi_evt;
  logic subst;

  mrt_pacer #(.PERIOD(PERIOD)) u_pacer (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .mii_clk (mii_tx_clk),
    .cap_evt (cap_evt),
    .hi_evt  (hi_evt)
  );

  mrt_errtrack u_err (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .cap_evt (cap_evt),
    .tx_en   (mac_tx_en),
    .tx_er   (mac_tx_er),
    .subst   (subst)
  );

  mrt_serializer u_ser (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .cap_evt (cap_evt),
    .hi_evt  (hi_evt),
    .nib     (mac_txd),
    .tx_en   (mac_tx_en),
    .subst   (subst),
    .txd     (rmii_txd),
    .txen    (rmii_tx_en)
  );

  always @(posedge ref_clk) begin
    if (!rst_n) begin
      a_r1_reset_outputs: assert (rmii_txd == 2'b00 && !rmii_tx_en && !mii_tx_clk);
    end
  end

  a_r3_capture_on_rise: assert property (@(posedge ref_clk) disable iff (!rst_n)
    cap_evt |=> mii_tx_clk);
  a_r3_high_on_fall: assert property (@(posedge ref_clk) disable iff (!rst_n)
    hi_evt |=> !mii_tx_clk);

endmodule

// File: tb/sim_mii_rmii_tx.sv
`timescale 1ns/1ps
module sim_mii_rmii_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] txd = 4'h0;
  logic       en = 1'b0;
  logic       er = 1'b0;
  logic       slow = 1'b0;

  logic       c0, c1, e0, e1;
  logic [1:0] d0, d1;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit berr = 0;

  always #4 clk = ~clk;

  mii_rmii_tx #(.LOW_SPEED(1'b0)) u0 (
    .ref_clk(clk), .rst_n(rst_n), .mac_txd(txd), .mac_tx_en(en), .mac_tx_er(er),
    .mii_tx_clk(c0), .rmii_txd(d0), .rmii_tx_en(e0));
  mii_rmii_tx #(.LOW_SPEED(1'b1), .SLOW_DIV(10)) u1 (
    .ref_clk(clk), .rst_n(rst_n), .mac_txd(txd), .mac_tx_en(en), .mac_tx_er(er),
    .mii_tx_clk(c1), .rmii_txd(d1), .rmii_tx_en(e1));

  wire       oclk = slow ? c1 : c0;
  wire [1:0] odat = slow ? d1 : d0;
  wire       oen  = slow ? e1 : e0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    en = 1'b0; er = 1'b0; txd = 4'h0;
    berr = 0;
    repeat (3) @(negedge clk);
    chk(odat == 2'b00 && oen == 1'b0 && oclk == 1'b0, "R1 outputs in reset",
        {odat, oen, oclk}, 0);
    rst_n = 1'b1;
  endtask

  // Drive one nibble (called at a negedge before the next capture), then check both dibits.
  task automatic send(input logic [3:0] nib, input bit ten, input bit ter, input string req);
    int p = slow ? 10 : 1;
    bit act_err;
    int exp_lo, exp_hi;
    bit held;
    txd = nib; en = ten; er = ter;
    act_err = ten && (ter || berr);
    berr = act_err;
    exp_lo = !ten ? 0 : (act_err ? 1 : (nib % 4));
    exp_hi = !ten ? 0 : (act_err ? 1 : (nib / 4));
    @(posedge oclk);
    @(negedge clk);
    chk(odat == exp_lo[1:0], {req, " low dibit (R3)"}, odat, exp_lo);
    chk(oen == ten, {req, " enable low half (R5)"}, oen, ten);
    held = 1;
    for (int i = 1; i < p; i++) begin
      @(negedge clk);
      if (odat != exp_lo[1:0] || oen != ten) held = 0;
    end
    if (p > 1) chk(held, {req, " low dibit hold (R4)"}, held, 1);
    @(negedge oclk);
    @(negedge clk);
    chk(odat == exp_hi[1:0], {req, " high dibit (R3)"}, odat, exp_hi);
    chk(oen == ten, {req, " enable high half (R5)"}, oen, ten);
    held = 1;
    for (int i = 1; i < p; i++) begin
      @(negedge clk);
      if (odat != exp_hi[1:0] || oen != ten) held = 0;
    end
    if (p > 1) chk(held, {req, " high dibit hold (R4)"}, held, 1);
  endtask

  task automatic measure(input int exp);
    int nh = 0;
    int nl = 0;
    @(posedge oclk);
    @(negedge clk);
    while (oclk) begin nh++; @(negedge clk); end
    while (!oclk) begin nl++; @(negedge clk); end
    chk(nh == exp, "R2 clock high time", nh, exp);
    chk(nl == exp, "R2 clock low time", nl, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // ---------- 100 Mbps copy ----------
    slow = 1'b0;
    do_reset();
    send(4'h0, 1'b0, 1'b0, "R6 idle");
    for (int v = 0; v < 16; v++) send(v[3:0], 1'b1, 1'b0, "R9 sweep");
    send(4'hF, 1'b0, 1'b1, "R6 idle with data and error");
    send(4'hA, 1'b1, 1'b0, "R5 frame start");
    send(4'h6, 1'b1, 1'b1, "R7 error nibble");
    send(4'hC, 1'b1, 1'b0, "R7 after error");
    send(4'h3, 1'b1, 1'b0, "R7 after error");
    send(4'h0, 1'b0, 1'b0, "R8 gap");
    send(4'hC, 1'b1, 1'b0, "R8 clean frame");
    send(4'h9, 1'b1, 1'b0, "R8 clean frame");
    send(4'h0, 1'b0, 1'b0, "R5 frame end");
    measure(1);
    // mid-run reset then resume
    send(4'h5, 1'b1, 1'b1, "R7 before reset");
    do_reset();
    send(4'h2, 1'b1, 1'b0, "R1 error cleared by reset");

    // ---------- 10 Mbps copy ----------
    slow = 1'b1;
    do_reset();
    measure(10);
    send(4'h0, 1'b0, 1'b0, "R6 slow idle");
    for (int v = 0; v < 16; v += 3) send(v[3:0], 1'b1, 1'b0, "R9 slow sweep");
    send(4'hE, 1'b1, 1'b1, "R7 slow error");
    send(4'hB, 1'b1, 1'b0, "R7 slow after error");
    send(4'h7, 1'b0, 1'b0, "R8 slow gap");
    send(4'hD, 1'b1, 1'b0, "R8 slow clean frame");
    send(4'h0, 1'b0, 1'b0, "R5 slow end");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule